// File: doc/BRIEF.md
# Pulse Period and High-Time Capture Unit

This block measures a digital waveform that arrives on one asynchronous input pin. It reports two numbers: the time from one rising edge to the next, and the time the input stays high after a rising edge. A free-running counter advances once every `psc+1` clocks. The synchronised rising edge restarts the counter. The same rising edge stores the old count as the period, and the falling edge that follows stores the count as the high-time. Software or a transfer engine then reads both numbers directly. No arithmetic is done inside the block.

Each capture can raise a one-cycle request pulse so that a transfer engine can fetch the value. Sticky capture flags and overcapture flags show values that were not read in time. The counter stops at its maximum value and sets a timeout flag, so a stalled input never produces a false period. A small register port is used to write the controls and to read the captures, the flags and the live count.

Captured values are one count less than the real duration. With `psc = 0`, an interval of N clocks reads back as N-1. Software recovers the frequency as f_clk/(period+1) and the high-time as capture+1.

Top module: `pulse_capture_unit`

## Requirements
- R1: After reset, every readable register (control at address 0, prescaler at 1, period at 2, high-time at 3, status at 4, live count at 5) reads 0, and both request outputs are low.
- R2: When the rising edge that follows an earlier armed rising edge arrives, the period register at address 2 takes `(N-1)/(psc+1)` (integer division). N is the spacing in clocks between the two rising edges. The counter restarts from 0 at the same edge.
- R3: On a falling edge after an armed rising edge, the high-time register at address 3 takes `(H-1)/(psc+1)`. H is the number of clocks the input was high.
- R4: The prescaler register (address 1) makes the counter advance once every `psc+1` clocks. The prescaler phase restarts on every rising edge.
- R5: The first rising edge after enable only arms the unit and captures nothing. A falling edge is ignored until a rising edge has been seen since enable.
- R6: If its enable bit is set, each capture raises a request pulse for exactly one clock. The period request is enabled by control bit 1 and the high-time request by control bit 2. The pulse rises on the third rising clock edge after the input changes, and the new capture value can be read from that same edge.
- R7: Status bit 0 (period) and status bit 1 (high-time) are set by a capture. Reading the matching capture register clears the bit.
- R8: Status bit 2 (period) and status bit 3 (high-time) are set when a capture happens while the matching capture flag is still set. Reading the matching capture register clears the bit.
- R9: While control bit 0 (run) is 0, the live count stays at 0. Edges on the input capture nothing and raise no flag and no request.
- R10: The counter stops at its all-ones maximum and does not wrap. While it is there, status bit 4 (timeout) is set. A rising or falling edge seen while the counter is stopped at its maximum captures nothing. The rising edge re-arms the unit. Reading status clears bit 4 once the counter has left its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| sigIn | input | 1 | Asynchronous waveform to measure |
| regAddr | input | 3 | Register address |
| regWe | input | 1 | Write strobe (addresses 0 and 1) |
| regRe | input | 1 | Read strobe. Clears the flags that belong to the address being read |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr, combinational |
| periodReq | output | 1 | One-cycle request: a new period value is available |
| widthReq | output | 1 | One-cycle request: a new high-time value is available |

## Verification
Constrained-random pulse pairs drive the main measurement. They use a random prescaler from 0 to 3 and random high and low lengths. One check compares the period against the rise-to-rise spacing and a second compares the high-time against the high length, which shows whether the two channels use opposite edges. Directed patterns cover single-clock high and low phases, where the synchroniser latency matters most, and prescaled cases where the integer division rounds down. An input held high past the counter maximum separates a true measurement from a saturated one. Enabling the unit in the middle of a high phase shows that the arming step is in place, and toggling the input while the unit is disabled confirms that nothing is recorded.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd5;

  // strobes issued by the control to the counter/capture datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capPeriod;
    logic capWidth;
  } cntStrobes_t;
endpackage

// File: rtl/ppm_ctrl.sv
module ppm_ctrl #(
  parameter int PSC_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sigIn,
  input  logic                   enable,
  input  logic [PSC_W-1:0]       psc,
  input  logic                   cntSat,
  output ppm_pkg::cntStrobes_t   strobes
);
  logic syncA, sigSync, sigPrev;
  logic rise, fall, tick, armed;
  logic [PSC_W-1:0] psCnt;

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      sigSync <= 1'b0;
      sigPrev <= 1'b0;
    end else begin
      syncA   <= sigIn;
      sigSync <= syncA;
      sigPrev <= sigSync;
    end
  end

  assign rise = sigSync & ~sigPrev;
  assign fall = ~sigSync & sigPrev;
  assign tick = enable && (psCnt == psc);

  always_ff @(posedge clk) begin
    if (!rstN)                      psCnt <= '0;
    else if (!enable || rise || tick) psCnt <= '0;
    else                            psCnt <= psCnt + 1'b1;
  end

  // armed once a rising edge has been seen since enable / saturation
  always_ff @(posedge clk) begin
    if (!rstN)        armed <= 1'b0;
    else if (!enable) armed <= 1'b0;
    else if (rise)    armed <= 1'b1;
    else if (cntSat)  armed <= 1'b0;
  end

  always_comb begin
    strobes.clrCnt    = !enable || rise;
    strobes.incCnt    = tick;
    strobes.capPeriod = enable && rise && armed && !cntSat;
    strobes.capWidth  = enable && fall && armed && !cntSat;
  end

  // R4
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incCnt && psc != '0) |=> (!strobes.incCnt || psc == '0));
endmodule

// File: rtl/ppm_datapath.sv
module ppm_datapath #(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ppm_pkg::cntStrobes_t strobes,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     periodCap,
  output logic [CNT_W-1:0]     widthCap,
  output logic                 cntSat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign cntSat = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN)                           cnt <= '0;
    else if (strobes.clrCnt)             cnt <= '0;
    else if (strobes.incCnt && !cntSat)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCap <= '0;
      widthCap  <= '0;
    end else begin
      if (strobes.capPeriod) periodCap <= cnt;
      if (strobes.capWidth)  widthCap  <= cnt;
    end
  end

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !strobes.clrCnt) |=> cnt == CNT_MAX);

  // R2
  period_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capPeriod |=> (cnt == '0 && periodCap == $past(cnt)));
endmodule

// File: rtl/ppm_regs.sv
module ppm_regs #(
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ppm_pkg::ADDR_W-1:0] regAddr,
  input  logic                       regWe,
  input  logic                       regRe,
  input  logic [DATA_W-1:0]          regWdata,
  output logic [DATA_W-1:0]          regRdata,
  input  logic                       capPeriod,
  input  logic                       capWidth,
  input  logic                       cntSat,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [CNT_W-1:0]           periodCap,
  input  logic [CNT_W-1:0]           widthCap,
  output logic                       enable,
  output logic [PSC_W-1:0]           psc,
  output logic                       periodReq,
  output logic                       widthReq
);
  import ppm_pkg::*;

  logic reqEnP, reqEnW;
  logic perFlag, widFlag, perOver, widOver, toFlag;
  logic rdPer, rdWid, rdStat;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:PSC_W];
  assign rdPer  = regRe && regAddr == A_PERIOD;
  assign rdWid  = regRe && regAddr == A_WIDTH;
  assign rdStat = regRe && regAddr == A_STATUS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      reqEnP <= 1'b0;
      reqEnW <= 1'b0;
      psc    <= '0;
    end else if (regWe) begin
      if (regAddr == A_CTRL) {reqEnW, reqEnP, enable} <= regWdata[2:0];
      if (regAddr == A_PSC)  psc <= regWdata[PSC_W-1:0];
    end
  end

  // flags: a capture wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perFlag <= 1'b0; widFlag <= 1'b0;
      perOver <= 1'b0; widOver <= 1'b0;
      toFlag  <= 1'b0;
    end else begin
      perFlag <= (perFlag & ~rdPer) | capPeriod;
      widFlag <= (widFlag & ~rdWid) | capWidth;
      perOver <= (perOver | (capPeriod & perFlag)) & ~rdPer;
      widOver <= (widOver | (capWidth & widFlag)) & ~rdWid;
      toFlag  <= (toFlag & ~rdStat) | cntSat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReq <= 1'b0;
      widthReq  <= 1'b0;
    end else begin
      periodReq <= capPeriod & reqEnP;
      widthReq  <= capWidth & reqEnW;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:   regRdata[2:0] = {reqEnW, reqEnP, enable};
      A_PSC:    regRdata[PSC_W-1:0] = psc;
      A_PERIOD: regRdata[CNT_W-1:0] = periodCap;
      A_WIDTH:  regRdata[CNT_W-1:0] = widthCap;
      A_STATUS: regRdata[4:0] = {toFlag, widOver, perOver, widFlag, perFlag};
      A_COUNT:  regRdata[CNT_W-1:0] = cnt;
      default:  regRdata = '0;
    endcase
  end

  // R8
  overcapture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perFlag && capPeriod && !rdPer) |=> perOver);

  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodReq |=> !periodReq);
endmodule

// File: rtl/pulse_capture_unit.sv
module pulse_capture_unit #(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sigIn,
  input  logic [ppm_pkg::ADDR_W-1:0] regAddr,
  input  logic                       regWe,
  input  logic                       regRe,
  input  logic [DATA_W-1:0]          regWdata,
  output logic [DATA_W-1:0]          regRdata,
  output logic                       periodReq,
  output logic                       widthReq
);
  ppm_pkg::cntStrobes_t strobes;
  logic                 enable, cntSat;
  logic [PSC_W-1:0]     psc;
  logic [CNT_W-1:0]     cnt, periodCap, widthCap;

  ppm_ctrl #(.PSC_W(PSC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .enable(enable),
    .psc(psc), .cntSat(cntSat), .strobes(strobes)
  );

  ppm_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cnt(cnt),
    .periodCap(periodCap), .widthCap(widthCap), .cntSat(cntSat)
  );

  ppm_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regRe(regRe), .regWdata(regWdata), .regRdata(regRdata),
    .capPeriod(strobes.capPeriod), .capWidth(strobes.capWidth),
    .cntSat(cntSat), .cnt(cnt), .periodCap(periodCap),
    .widthCap(widthCap), .enable(enable), .psc(psc),
    .periodReq(periodReq), .widthReq(widthReq)
  );

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!periodReq && !widthReq));
endmodule

// File: tb/sim_pulse_capture_unit.sv
module sim_pulse_capture_unit;
  localparam int CW = 12;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rstN = 1'b0, sigIn = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic periodReq, widthReq;
  int tests = 0, fails = 0, pReqN = 0, wReqN = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  pulse_capture_unit #(.CNT_W(CW), .PSC_W(16), .DATA_W(32)) u0 (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .regAddr(regAddr),
    .regWe(regWe), .regRe(regRe), .regWdata(regWdata),
    .regRdata(regRdata), .periodReq(periodReq), .widthReq(widthReq)
  );

  always @(negedge clk) if (rstN) begin
    if (periodReq) pReqN++;
    if (widthReq)  wReqN++;
  end

  function automatic int expCnt(int cycles, int psc);
    return (cycles - 1) / (psc + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRe = 1'b1;
    #1 d = regRdata;
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic clearAll();
    logic [31:0] t;
    rd(3'd2, t); rd(3'd3, t); rd(3'd4, t);
  endtask

  // two high/low cycles; checks R2 R3 R4 R6 R7 R8
  task automatic runPair(int psc, int h, int l, logic [1:0] reqEn);
    int p0, w0;
    wr(3'd0, 0);
    sigIn = 1'b0;
    wr(3'd1, psc);
    clearAll();
    wr(3'd0, {29'd0, reqEn, 1'b1});
    wcyc(4);
    p0 = pReqN; w0 = wReqN;
    @(negedge clk); sigIn = 1'b1;
    wcyc(h); sigIn = 1'b0;
    wcyc(l); sigIn = 1'b1;
    wcyc(h); sigIn = 1'b0;
    wcyc(l + 4);
    rd(3'd4, v); chk("R7 R8 status after pair", v, 32'd11);
    rd(3'd2, v); chk("R2 R4 period", v, expCnt(h + l, psc));
    rd(3'd3, v); chk("R3 R4 high-time", v, expCnt(h, psc));
    rd(3'd4, v); chk("R7 R8 status cleared by reads", v, 32'd0);
    chk("R6 period requests", pReqN - p0, reqEn[0] ? 1 : 0);
    chk("R6 high-time requests", wReqN - w0, reqEn[1] ? 2 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seedv;
    seedv = $urandom(32'h5eed);
    wcyc(3); rstN = 1'b1; wcyc(1);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); chk("R1 reset register", v, 0);
    end
    chk("R1 periodReq low", {31'd0, periodReq}, 0);
    chk("R1 widthReq low", {31'd0, widthReq}, 0);

    // directed corner pairs
    runPair(0, 1, 1, 2'b11);
    runPair(3, 1, 1, 2'b11);
    runPair(2, 10, 5, 2'b01);
    runPair(1, 7, 9, 2'b00);
    runPair(0, 3, 3, 2'b10);

    // constrained random pairs
    for (int i = 0; i < 24; i++) begin
      int ps, hh, ll;
      ps = $urandom % 4;
      hh = 1 + $urandom % 40;
      ll = 1 + $urandom % 40;
      runPair(ps, hh, ll, 2'($urandom % 4));
    end

    // R6 latency: request on third edge after the input change
    wr(3'd0, 0); sigIn = 1'b0; wr(3'd1, 0); clearAll();
    wr(3'd0, 7); wcyc(3);
    sigIn = 1'b1; wcyc(5); sigIn = 1'b0; wcyc(5);
    sigIn = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R6 no request after 2 edges", {31'd0, periodReq}, 0);
    @(negedge clk); chk("R6 request at edge 3", {31'd0, periodReq}, 1);
    @(negedge clk); chk("R6 request lasts one cycle", {31'd0, periodReq}, 0);

    // R5 first rising edge only arms
    wr(3'd0, 0); sigIn = 1'b0; clearAll();
    wr(3'd0, 7); wcyc(3);
    sigIn = 1'b1; wcyc(6);
    rd(3'd4, v); chk("R5 first rise captures nothing", v, 0);
    sigIn = 1'b0; wcyc(6);
    rd(3'd4, v); chk("R5 fall after armed rise captured", v, 2);
    rd(3'd3, v); chk("R5 R3 high-time after arming", v, 7);
    // enabled during a high phase: the fall is ignored
    wr(3'd0, 0); sigIn = 1'b1; wcyc(4); clearAll();
    wr(3'd0, 7); wcyc(4);
    sigIn = 1'b0; wcyc(6);
    rd(3'd4, v); chk("R5 unarmed fall ignored", v, 0);

    // R9 disabled: no counting, no captures
    wr(3'd0, 0); clearAll();
    begin
      int p0, w0;
      p0 = pReqN; w0 = wReqN;
      for (int k = 0; k < 4; k++) begin
        sigIn = 1'b1; wcyc(5); sigIn = 1'b0; wcyc(5);
      end
      rd(3'd5, v); chk("R9 count held at zero", v, 0);
      rd(3'd4, v); chk("R9 no flags while disabled", v, 0);
      chk("R9 no requests while disabled", (pReqN - p0) + (wReqN - w0), 0);
    end

    // R10 saturation and timeout
    wr(3'd1, 0); sigIn = 1'b0; clearAll();
    wr(3'd0, 7); wcyc(3);
    sigIn = 1'b1; wcyc(MAXC + 100);
    rd(3'd5, v); chk("R10 count stops at max", v, MAXC);
    rd(3'd4, v); chk("R10 timeout flag", v, 16);
    sigIn = 1'b0; wcyc(6);
    sigIn = 1'b1; wcyc(6);
    rd(3'd4, v); chk("R10 no capture from saturated count", v, 16);
    rd(3'd4, v); chk("R10 timeout cleared by status read", v, 0);
    rd(3'd5, v); chk("R10 count restarted after re-arm", {31'd0, v < 32}, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule